// File: doc/BRIEF.md
# Segmented Thermometer Current-Switch Decoder

This block turns an 8-bit straight-binary converter code into the switch controls of a segmented current-steering array. The code is split into two parts:

- The upper five bits select how many of 31 equal coarse segments are steered to output A.
- The lower three bits select how many of 7 equal fine units, each worth one eighth of a segment, are steered to output A.

Both sections are unary. Every control is set in thermometer order from bit 0 upward. Every source not steered to A is steered to B, so each A vector and its B vector are bitwise complements.

The code is taken on a rising clock edge while the load enable is high. Otherwise the last loaded code is kept. Every switch output is registered, so a new code appears at the switch outputs one clock after the edge that loaded it.

A sleep input turns every current source off by clearing both the A and the B vectors. When sleep is released, the outputs return to the decoded value of the held code.

Top module: `cs_segment_decoder`

## Requirements
- R1: The number of set bits in `seg_a_o` equals code bits [7:3]. The set bits occupy positions 0 upward with no gaps.
- R2: The number of set bits in `unit_a_o` equals code bits [2:0]. The set bits occupy positions 0 upward with no gaps.
- R3: While not sleeping, `seg_b_o` equals the bitwise inverse of `seg_a_o`, and `unit_b_o` equals the bitwise inverse of `unit_a_o`.
- R4: Code 255 gives all 31 segment and all 7 unit A controls set, with both B vectors zero. Code 0 gives both A vectors zero, with both B vectors all ones.
- R5: A code presented with `load_en_i` high at a rising edge appears decoded on the outputs immediately after that edge, which is one clock of latency.
- R6: With `load_en_i` low, `code_i` is ignored, and the outputs keep the decoding of the last loaded code.
- R7: At each edge where `sleep_i` is high, all four switch vectors become zero. A code loaded during sleep is still held. At the first edge after `sleep_i` falls, the outputs show the decoding of the held code.
- R8: At an edge where `rst_n` is low, both A vectors become zero, both B vectors become all ones, and the held code becomes 0.
- R9: While not sleeping, eight times the count of set `seg_a_o` bits plus the count of set `unit_a_o` bits equals the held code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| code_i | input | 8 | Straight-binary converter code |
| load_en_i | input | 1 | Load the code at this edge |
| sleep_i | input | 1 | Turn every source off |
| seg_a_o | output | 31 | Coarse segment controls toward output A |
| seg_b_o | output | 31 | Coarse segment controls toward output B |
| unit_a_o | output | 7 | Fine unit controls toward output A |
| unit_b_o | output | 7 | Fine unit controls toward output B |

## Verification
A wrong held code or a misdecoded bit shows at the ports on the very next edge as an A weight that differs from the loaded code, or as a gap in a thermometer vector. A broken complement path shows as a source that is driven to both outputs or to neither while awake.

Sleep and hold faults appear one edge after the stimulus. Either the outputs fail to clear, or they resume from a code other than the one last loaded. An exhaustive sweep of all 256 codes and a random mix of load, hold and sleep compare every output on every clock against a behavioural model.

// File: rtl/segdec_pkg.sv
// Package: shared defaults and a helper for the segmented decoder.
// Assumes: codes are unsigned straight binary.
package segdec_pkg;
    localparam int DEF_CODE_W = 8;   // total code width
    localparam int DEF_MSB_W  = 5;   // bits decoded into coarse segments

    // Number of unary elements a binary field of width w can select.
    function automatic int unary_count(input int w);
        return (1 << w) - 1;
    endfunction
endpackage

// File: rtl/segdec_code_latch.sv
// Module: holds the last loaded code and presents the code that the
// next edge will decode.
// Assumes: load_en_i is synchronous to clk.
module segdec_code_latch #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic              load_en_i,
    output logic [CODE_W-1:0] next_code_o
);
    logic [CODE_W-1:0] held_q;

    // Capture the code on load; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (load_en_i) begin
            held_q <= code_i;
        end
    end

    // Select the code the output stage will decode at this edge.
    always_comb begin
        next_code_o = load_en_i ? code_i : held_q;
    end
endmodule

// File: rtl/segdec_thermo.sv
// Module: binary-to-thermometer decoder, purely combinational.
// Output bit k is set when the binary value exceeds k.
// Assumes: N_OUT = 2**BIN_W - 1.
module segdec_thermo #(
    parameter int BIN_W = 5,
    parameter int N_OUT = (1 << BIN_W) - 1
) (
    input  logic [BIN_W-1:0] bin_i,
    output logic [N_OUT-1:0] therm_o
);
    // One magnitude comparator per output position.
    for (genvar k = 0; k < N_OUT; k++) begin : g_cmp
        localparam logic [BIN_W-1:0] THRESH = BIN_W'(k);
        assign therm_o[k] = (bin_i > THRESH);
    end
endmodule

// File: rtl/segdec_switch_drv.sv
// Module: registered complementary switch drive for one section.
// Awake: A follows the thermometer and B is its inverse.
// Asleep: both sides are cleared.
// Assumes: sleep_i is synchronous to clk.
module segdec_switch_drv #(
    parameter int WIDTH = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_i,
    input  logic [WIDTH-1:0] therm_i,
    output logic [WIDTH-1:0] a_o,
    output logic [WIDTH-1:0] b_o
);
    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;

    // Register the A and B drive, with reset and sleep overrides.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '1;
        end else if (sleep_i) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            a_q <= therm_i;
            b_q <= ~therm_i;
        end
    end

    // Drive the ports from the registers.
    always_comb begin
        a_o = a_q;
        b_o = b_q;
    end
endmodule

// File: rtl/cs_segment_decoder.sv
// Module: top of the segmented current-switch decoder.
// Splits the code into a coarse field and a fine field, thermometer-
// decodes each, and registers complementary A/B drive for both.
// Assumes: a single clock domain and a synchronous active-low reset.
module cs_segment_decoder
    import segdec_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W,
    parameter int MSB_W  = DEF_MSB_W,
    parameter int LSB_W  = CODE_W - MSB_W,
    parameter int SEG_N  = (1 << MSB_W) - 1,
    parameter int UNIT_N = (1 << LSB_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic              load_en_i,
    input  logic              sleep_i,
    output logic [SEG_N-1:0]  seg_a_o,
    output logic [SEG_N-1:0]  seg_b_o,
    output logic [UNIT_N-1:0] unit_a_o,
    output logic [UNIT_N-1:0] unit_b_o
);
    logic [CODE_W-1:0] next_code;
    logic [MSB_W-1:0]  coarse_field;
    logic [LSB_W-1:0]  fine_field;
    logic [SEG_N-1:0]  seg_therm;
    logic [UNIT_N-1:0] unit_therm;

    segdec_code_latch #(.CODE_W(CODE_W)) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .code_i      (code_i),
        .load_en_i   (load_en_i),
        .next_code_o (next_code)
    );

    // Split the code into its coarse and fine fields.
    always_comb begin
        coarse_field = next_code[CODE_W-1:LSB_W];
        fine_field   = next_code[LSB_W-1:0];
    end

    segdec_thermo #(.BIN_W(MSB_W), .N_OUT(SEG_N)) u_seg_dec (
        .bin_i   (coarse_field),
        .therm_o (seg_therm)
    );

    segdec_thermo #(.BIN_W(LSB_W), .N_OUT(UNIT_N)) u_unit_dec (
        .bin_i   (fine_field),
        .therm_o (unit_therm)
    );

    segdec_switch_drv #(.WIDTH(SEG_N)) u_seg_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep_i (sleep_i),
        .therm_i (seg_therm),
        .a_o     (seg_a_o),
        .b_o     (seg_b_o)
    );

    segdec_switch_drv #(.WIDTH(UNIT_N)) u_unit_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep_i (sleep_i),
        .therm_i (unit_therm),
        .a_o     (unit_a_o),
        .b_o     (unit_b_o)
    );
endmodule

// File: rtl/segdec_checker.sv
// Module: property checker for cs_segment_decoder, attached by bind.
// Observes ports only.
// Assumes: the same parameters as the top module.
module segdec_checker #(
    parameter int CODE_W = 8,
    parameter int MSB_W  = 5,
    parameter int LSB_W  = CODE_W - MSB_W,
    parameter int SEG_N  = (1 << MSB_W) - 1,
    parameter int UNIT_N = (1 << LSB_W) - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] code_i,
    input logic              load_en_i,
    input logic              sleep_i,
    input logic [SEG_N-1:0]  seg_a_o,
    input logic [SEG_N-1:0]  seg_b_o,
    input logic [UNIT_N-1:0] unit_a_o,
    input logic [UNIT_N-1:0] unit_b_o
);
    localparam logic [SEG_N-1:0]  SEG_ONE  = SEG_N'(1);
    localparam logic [UNIT_N-1:0] UNIT_ONE = UNIT_N'(1);
    localparam int                WEIGHT   = 1 << LSB_W;

    logic seen_edge;  // set after the first clock edge
    logic run_ok;     // set one edge after reset is released

    // Track whether $past values are meaningful.
    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
        run_ok    <= rst_n;
    end

    AST_THERMO_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        ((seg_a_o & (seg_a_o + SEG_ONE)) == '0)); // R1

    AST_THERMO_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((unit_a_o & (unit_a_o + UNIT_ONE)) == '0)); // R2

    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ok && !$past(sleep_i)) |-> ((seg_b_o == ~seg_a_o) && (unit_b_o == ~unit_a_o))); // R3

    AST_LOAD_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ok && $past(load_en_i) && !$past(sleep_i)) |->
        ((WEIGHT * $countones(seg_a_o) + $countones(unit_a_o)) == int'($past(code_i)))); // R5

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ok && !$past(load_en_i) && !$past(sleep_i) && ($past(seg_b_o) != '0 || $past(seg_a_o) != '0))
        |-> ($stable(seg_a_o) && $stable(unit_a_o))); // R6

    AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ok && $past(sleep_i)) |->
        (seg_a_o == '0 && seg_b_o == '0 && unit_a_o == '0 && unit_b_o == '0)); // R7

    AST_RESET_STATE: assert property (@(posedge clk)
        (seen_edge && !$past(rst_n)) |->
        (seg_a_o == '0 && unit_a_o == '0 && seg_b_o == '1 && unit_b_o == '1)); // R8
endmodule

bind cs_segment_decoder segdec_checker #(
    .CODE_W(CODE_W), .MSB_W(MSB_W), .LSB_W(LSB_W), .SEG_N(SEG_N), .UNIT_N(UNIT_N)
) u_segdec_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_i    (code_i),
    .load_en_i (load_en_i),
    .sleep_i   (sleep_i),
    .seg_a_o   (seg_a_o),
    .seg_b_o   (seg_b_o),
    .unit_a_o  (unit_a_o),
    .unit_b_o  (unit_b_o)
);

// File: tb/tb_cs_segment_decoder.sv
// Bench: behavioural per-clock model compared on every edge.
module tb_cs_segment_decoder;
    localparam int SEG_N  = 31;
    localparam int UNIT_N = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        code_i = '0;
    logic              load_en_i = 1'b0;
    logic              sleep_i = 1'b0;
    logic [SEG_N-1:0]  seg_a_o, seg_b_o;
    logic [UNIT_N-1:0] unit_a_o, unit_b_o;

    int n_cmp  = 0;
    int n_bad  = 0;
    int held   = 0;
    bit done   = 1'b0;

    cs_segment_decoder dut (
        .clk(clk), .rst_n(rst_n), .code_i(code_i), .load_en_i(load_en_i),
        .sleep_i(sleep_i), .seg_a_o(seg_a_o), .seg_b_o(seg_b_o),
        .unit_a_o(unit_a_o), .unit_b_o(unit_b_o)
    );

    always #2 clk = ~clk;

    function automatic logic [SEG_N-1:0] ones_seg(input int n);
        logic [SEG_N-1:0] v = '0;
        for (int k = 0; k < n; k++) v[k] = 1'b1;
        return v;
    endfunction

    function automatic logic [UNIT_N-1:0] ones_unit(input int n);
        logic [UNIT_N-1:0] v = '0;
        for (int k = 0; k < n; k++) v[k] = 1'b1;
        return v;
    endfunction

    task automatic cmp_seg(input string tag, input string nm,
                           input logic [SEG_N-1:0] act, input logic [SEG_N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
        end
    endtask

    task automatic cmp_unit(input string tag, input string nm,
                            input logic [UNIT_N-1:0] act, input logic [UNIT_N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
        end
    endtask

    // Drive one cycle, advance the model, and compare just after the edge.
    task automatic step(input int c, input bit en, input bit sl, input string tag);
        logic [SEG_N-1:0]  ea, eb;
        logic [UNIT_N-1:0] ua, ub;
        code_i    = 8'(c);
        load_en_i = en;
        sleep_i   = sl;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            held = 0;
            ea = '0; eb = '1; ua = '0; ub = '1;
        end else begin
            if (en) held = c;
            if (sl) begin
                ea = '0; eb = '0; ua = '0; ub = '0;
            end else begin
                ea = ones_seg(held / 8);
                ua = ones_unit(held % 8);
                eb = ~ea;
                ub = ~ua;
            end
        end
        cmp_seg(tag, "seg_a", seg_a_o, ea);
        cmp_seg(tag, "seg_b", seg_b_o, eb);
        cmp_unit(tag, "unit_a", unit_a_o, ua);
        cmp_unit(tag, "unit_b", unit_b_o, ub);
    endtask

    initial begin
        // R8: reset state, even with a nonzero code and load requested
        rst_n = 1'b0;
        step(8'hC3, 1'b1, 1'b0, "R8");
        step(8'h11, 1'b1, 1'b0, "R8");
        rst_n = 1'b1;
        // R4: extremes
        step(0, 1'b1, 1'b0, "R4");
        step(255, 1'b1, 1'b0, "R4");
        // R1: coarse only (5 segments, 0 units)
        step(8'h28, 1'b1, 1'b0, "R1");
        step(8'hF8, 1'b1, 1'b0, "R1");
        // R2: fine only
        step(8'h05, 1'b1, 1'b0, "R2");
        step(8'h07, 1'b1, 1'b0, "R2");
        // R9 / R3: mixed codes
        step(8'hA7, 1'b1, 1'b0, "R9");
        step(8'h80, 1'b1, 1'b0, "R3");
        // R5: one-clock latency from load
        step(8'h40, 1'b1, 1'b0, "R5");
        // R6: load disabled, code ignored
        step(8'hFF, 1'b0, 1'b0, "R6");
        step(8'h01, 1'b0, 1'b0, "R6");
        // R7: sleep clears all, a code loaded while asleep is kept
        step(8'h33, 1'b1, 1'b1, "R7");
        step(8'h99, 1'b0, 1'b1, "R7");
        step(8'h00, 1'b0, 1'b0, "R7");
        // R9: exhaustive sweep
        for (int c = 0; c < 256; c++) step(c, 1'b1, 1'b0, "R9");
        // R3: random mix of load, hold and sleep
        for (int i = 0; i < 400; i++)
            step(int'($urandom_range(0, 255)), bit'($urandom_range(0, 1)),
                 ($urandom_range(0, 5) == 0), "R3");
        // R8: reset after activity
        rst_n = 1'b0;
        step(8'h77, 1'b1, 1'b0, "R8");
        rst_n = 1'b1;
        step(8'h00, 1'b0, 1'b0, "R8");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule